// File: doc/BRIEF.md
# Key-Gated One-Time-Programmable Fuse Controller

This block fronts a small one-time-programmable fuse store. The store is modelled inside the block as a word-organised register array. Software reaches it over a plain 32-bit register bus made of an address, a write strobe, write data and a combinational read-data return. There are two routes in.

The first route is a read-only window. Every fuse byte N is visible at bus address window-base + N. Words inside a parameterised locked range read as zero through this window.

The second route is a command register that must carry an unlock key together with a fuse byte offset. Software sets either a fetch bit or a burn bit in that register. The sequencer then stays busy for a fixed, parameterised number of cycles. At the end it clears the bit. A fetch places the addressed word in a result register. A burn ORs the pattern register into the addressed word, so fuse bits can only ever move from 0 to 1. Software polls the command bit to learn that the operation is complete.

Top module: `otp_guard`

## Requirements
- R1: After reset the command register (0x40), pattern register (0x50), result register (0x60) and every fuse word read as zero.
- R2: The command register reads back as follows: bits [23:16] hold the byte offset, bits [15:8] the key byte, bit 1 the fetch bit and bit 0 the burn bit; all other bits read 0. The pattern register at 0x50 reads back the last value written.
- R3: A command write with key 0xAC and bit 1 set, made while idle, raises bit 1. Bit 1 stays high for exactly RD_LAT cycles and then clears. In that same edge the result register at 0x60 takes the fuse word.
- R4: Bits [1:0] of a fuse byte offset are ignored, for the command path (word index = offset[7:2]) and for the window alike. Within a word, byte offset 4i+j occupies bits [8j+7:8j].
- R5: A command write with key 0xAC and bit 0 set raises bit 0 for RD_LAT cycles. On completion the addressed word becomes old OR pattern; a set bit never returns to 0.
- R6: A command write whose key byte is not 0xAC leaves both command bits clear. It causes no array access: the result register and the fuse words are unchanged, though the offset and key fields record the written values.
- R7: Any command-register write made while bit 0 or bit 1 is set is ignored entirely.
- R8: A keyed write with both bit 1 and bit 0 set performs a fetch only; bit 0 stays clear and no burn occurs.
- R9: A read of window address 0x200+N returns fuse word N/4 (0x200 to 0x2FF). For words LOCK_FIRST to LOCK_LAST (default 12 to 15) the window returns zero, while the command path still reaches them.
- R10: Writes to the window and to the result register have no effect. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The assertions assume that the bus address and write data are held steady and free of X whenever the write strobe is high. They also assume that reset is held for at least one clock edge before any access. The monotonic-fuse check relies on the command offset changing only through an accepted command-register write. The bench drives every access at the falling edge and keeps it stable across the following rising edge. It drops the strobe afterwards and releases reset only after several edges, so these assumptions always hold.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam logic [7:0] UNLOCK_KEY = 8'hAC;

  typedef enum logic [1:0] {OP_NONE, OP_FETCH, OP_BURN} op_e;

  typedef struct packed {
    logic [7:0] off;
    logic [7:0] key;
    logic       fetch;
    logic       burn;
  } cmd_t;

  // Decode a command write: wrong key gives no op, fetch wins over burn.
  function automatic op_e decode_op(input logic [31:0] w);
    if (w[15:8] != UNLOCK_KEY) return OP_NONE;
    if (w[1])                  return OP_FETCH;
    if (w[0])                  return OP_BURN;
    return OP_NONE;
  endfunction

  function automatic logic [31:0] pack_cmd(input cmd_t c);
    return {8'h00, c.off, c.key, 6'b0, c.fetch, c.burn};
  endfunction

  // Fuse programming can only set bits.
  function automatic logic [31:0] burn_word(input logic [31:0] old_w,
                                            input logic [31:0] pat);
    return old_w | pat;
  endfunction

  function automatic logic in_lock(input int unsigned idx,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (idx >= lo) && (idx <= hi);
  endfunction

endpackage

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_pkg::*;
#(
  parameter int unsigned LAT = 4,
  localparam int unsigned CW = $clog2(LAT + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [31:0]   wdata,
  output cmd_t          cmd_q,
  output logic          busy,
  output logic          accept,
  output logic          fin_fetch,
  output logic          fin_burn,
  output logic [CW-1:0] cnt
);

  op_e           op;
  logic [CW-1:0] cnt_q;
  logic          fin;

  assign op        = decode_op(wdata);
  assign busy      = cmd_q.fetch | cmd_q.burn;
  assign accept    = cmd_we && !busy && (op != OP_NONE);
  assign fin       = busy && (cnt_q == '0);
  assign fin_fetch = fin && cmd_q.fetch;
  assign fin_burn  = fin && cmd_q.burn;
  assign cnt       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cnt_q <= '0;
    end else if (cmd_we && !busy) begin
      cmd_q.off   <= wdata[23:16];
      cmd_q.key   <= wdata[15:8];
      cmd_q.fetch <= (op == OP_FETCH);
      cmd_q.burn  <= (op == OP_BURN);
      cnt_q       <= CW'(LAT - 1);
    end else if (fin) begin
      cmd_q.fetch <= 1'b0;
      cmd_q.burn  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  localparam int unsigned IDX_W = $clog2(WORDS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burn_en,
  input  logic [IDX_W-1:0] burn_idx,
  input  logic [31:0]      burn_pat,
  input  logic [IDX_W-1:0] a_idx,
  output logic [31:0]      a_word,
  input  logic [IDX_W-1:0] b_idx,
  output logic [31:0]      b_word
);

  logic [31:0] cells [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cells[i] <= '0;
    end else if (burn_en) begin
      cells[burn_idx] <= burn_word(cells[burn_idx], burn_pat);
    end
  end

  assign a_word = cells[a_idx];
  assign b_word = cells[b_idx];

endmodule

// File: rtl/otp_readmux.sv
module otp_readmux (
  input  logic        sel_cmd,
  input  logic        sel_pat,
  input  logic        sel_res,
  input  logic        sel_win,
  input  logic        win_locked,
  input  logic [31:0] cmd_word,
  input  logic [31:0] pat_word,
  input  logic [31:0] res_word,
  input  logic [31:0] win_word,
  output logic [31:0] rdata
);

  always_comb begin
    rdata = '0;
    if (sel_win)      rdata = win_locked ? 32'h0 : win_word;
    else if (sel_cmd) rdata = cmd_word;
    else if (sel_pat) rdata = pat_word;
    else if (sel_res) rdata = res_word;
  end

endmodule

// File: rtl/otp_guard.sv
module otp_guard
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned FUSE_WORDS = 64,
  parameter int unsigned RD_LAT     = 4,
  parameter int unsigned LOCK_FIRST = 12,
  parameter int unsigned LOCK_LAST  = 15,
  parameter int unsigned CMD_OFS    = 'h40,
  parameter int unsigned PAT_OFS    = 'h50,
  parameter int unsigned RES_OFS    = 'h60,
  parameter int unsigned WIN_OFS    = 'h200
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int unsigned IDX_W   = $clog2(FUSE_WORDS);
  localparam int unsigned CW      = $clog2(RD_LAT + 1);
  localparam int unsigned WIN_END = WIN_OFS + 4 * FUSE_WORDS;

  // decode
  logic sel_cmd, sel_pat, sel_res, sel_win;
  assign sel_cmd = (32'(bus_addr) == CMD_OFS);
  assign sel_pat = (32'(bus_addr) == PAT_OFS);
  assign sel_res = (32'(bus_addr) == RES_OFS);
  assign sel_win = (32'(bus_addr) >= WIN_OFS) && (32'(bus_addr) < WIN_END);

  logic cmd_we;
  assign cmd_we = bus_we && sel_cmd;

  // command sequencer
  cmd_t          cmd_q;
  logic          busy, cmd_accept, fin_fetch, fin_burn;
  logic [CW-1:0] seq_cnt;

  otp_cmd_seq #(.LAT(RD_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .wdata     (bus_wdata),
    .cmd_q     (cmd_q),
    .busy      (busy),
    .accept    (cmd_accept),
    .fin_fetch (fin_fetch),
    .fin_burn  (fin_burn),
    .cnt       (seq_cnt)
  );

  logic ctl_fetch, ctl_burn;
  logic [7:0] ctl_off;
  assign ctl_fetch = cmd_q.fetch;
  assign ctl_burn  = cmd_q.burn;
  assign ctl_off   = cmd_q.off;

  // pattern and result registers
  logic [31:0] pat_q, res_q;
  logic [31:0] ind_word, win_word;
  logic [IDX_W-1:0] ind_idx, win_idx;
  logic [31:0] win_rel;

  assign ind_idx = ctl_off[IDX_W+1:2];
  assign win_rel = 32'(bus_addr) - WIN_OFS;
  assign win_idx = win_rel[IDX_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      res_q <= '0;
    end else begin
      if (bus_we && sel_pat) pat_q <= bus_wdata;
      if (fin_fetch)         res_q <= ind_word;
    end
  end

  otp_array #(.WORDS(FUSE_WORDS)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .burn_en  (fin_burn),
    .burn_idx (ind_idx),
    .burn_pat (pat_q),
    .a_idx    (ind_idx),
    .a_word   (ind_word),
    .b_idx    (win_idx),
    .b_word   (win_word)
  );

  logic win_locked;
  assign win_locked = in_lock(32'(win_idx), LOCK_FIRST, LOCK_LAST);

  otp_readmux u_mux (
    .sel_cmd    (sel_cmd),
    .sel_pat    (sel_pat),
    .sel_res    (sel_res),
    .sel_win    (sel_win),
    .win_locked (win_locked),
    .cmd_word   (pack_cmd(cmd_q)),
    .pat_word   (pat_q),
    .res_word   (res_q),
    .win_word   (win_word),
    .rdata      (bus_rdata)
  );

endmodule

// File: rtl/otp_guard_chk.sv
module otp_guard_chk #(
  parameter int unsigned LAT   = 4,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CW    = 3
)(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [31:0]      bus_wdata,
  input logic             busy,
  input logic             cmd_accept,
  input logic             fin_fetch,
  input logic             fin_burn,
  input logic             ctl_fetch,
  input logic             ctl_burn,
  input logic [7:0]       ctl_off,
  input logic [CW-1:0]    seq_cnt,
  input logic [31:0]      res_q,
  input logic [IDX_W-1:0] ind_idx,
  input logic [31:0]      ind_word
);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);

  // R3
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_fetch || fin_burn) |=> !busy);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(seq_cnt) < LAT));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_fetch && !fin_burn) |=> (busy && $stable(ctl_off)));

  // R6
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && bus_wdata[15:8] != 8'hAC) |=> !busy);

  // R8
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_fetch, ctl_burn}));

  // R5
  fuse_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ind_idx) |-> ((ind_word & $past(ind_word)) == $past(ind_word)));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_fetch |=> $stable(res_q));

endmodule

bind otp_guard otp_guard_chk #(.LAT(RD_LAT), .IDX_W(IDX_W), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_we     (cmd_we),
  .bus_wdata  (bus_wdata),
  .busy       (busy),
  .cmd_accept (cmd_accept),
  .fin_fetch  (fin_fetch),
  .fin_burn   (fin_burn),
  .ctl_fetch  (ctl_fetch),
  .ctl_burn   (ctl_burn),
  .ctl_off    (ctl_off),
  .seq_cnt    (seq_cnt),
  .res_q      (res_q),
  .ind_idx    (ind_idx),
  .ind_word   (ind_word)
);

// File: tb/test_otp_guard.sv
module test_otp_guard;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  otp_guard i_otp_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata)
  );

  function automatic logic [31:0] mk(input logic [7:0] off, input logic [7:0] key,
                                     input logic fe, input logic bu);
    return {8'h00, off, key, 6'b0, fe, bu};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1;
    d = rdata;
  endtask

  // Called right after a command write; counts cycles until both bits clear.
  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      rd(12'h040, v);
      if (v[1:0] == 2'b00) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h040, v); check("R1", "cmd reg", v, 32'h0);
    rd(12'h050, v); check("R1", "pattern reg", v, 32'h0);
    rd(12'h060, v); check("R1", "result reg", v, 32'h0);
    rd(12'h200, v); check("R1", "fuse word 0", v, 32'h0);
    rd(12'h2FC, v); check("R1", "fuse word 63", v, 32'h0);
  endtask

  task automatic t_burn();
    logic [31:0] v; int n;
    wr(12'h050, 32'h44332211);
    rd(12'h050, v); check("R2", "pattern readback", v, 32'h44332211);
    wr(12'h040, mk(8'h08, 8'hAC, 1'b0, 1'b1));
    rd(12'h040, v); check("R2", "cmd readback burn", v, 32'h0008AC01);
    wait_idle(n);   check("R5", "burn latency", n, LAT);
    rd(12'h208, v); check("R5", "burned word", v, 32'h44332211);
    wr(12'h050, 32'h000000F0);
    wr(12'h040, mk(8'h08, 8'hAC, 1'b0, 1'b1));
    wait_idle(n);
    rd(12'h208, v); check("R5", "OR merge", v, 32'h443322F1);
    wr(12'h050, 32'h00000000);
    wr(12'h040, mk(8'h08, 8'hAC, 1'b0, 1'b1));
    wait_idle(n);
    rd(12'h208, v); check("R5", "no clear", v, 32'h443322F1);
  endtask

  task automatic t_fetch();
    logic [31:0] v; int n;
    wr(12'h040, mk(8'h08, 8'hAC, 1'b1, 1'b0));
    rd(12'h040, v); check("R2", "cmd readback fetch", v, 32'h0008AC02);
    rd(12'h060, v); check("R3", "result before finish", v, 32'h0);
    wait_idle(n);   check("R3", "fetch latency", n, LAT);
    rd(12'h060, v); check("R3", "fetched word", v, 32'h443322F1);
  endtask

  task automatic t_lanes();
    logic [31:0] v; int n;
    wr(12'h050, 32'hCAFE0001);
    wr(12'h040, mk(8'h0F, 8'hAC, 1'b0, 1'b1));
    wait_idle(n);
    rd(12'h20C, v); check("R4", "burn via offset 0x0F lands in word 3", v, 32'hCAFE0001);
    wr(12'h040, mk(8'h0B, 8'hAC, 1'b1, 1'b0));
    wait_idle(n);
    rd(12'h060, v); check("R4", "fetch offset 0x0B", v, 32'h443322F1);
    rd(12'h20B, v); check("R4", "window 0x20B", v, 32'h443322F1);
  endtask

  task automatic t_badkey();
    logic [31:0] v; int n;
    wr(12'h040, mk(8'h10, 8'hAB, 1'b1, 1'b0));
    rd(12'h040, v); check("R6", "bad key fetch bits", v, 32'h0010AB00);
    repeat (LAT + 2) @(negedge clk);
    rd(12'h060, v); check("R6", "result unchanged", v, 32'h443322F1);
    wr(12'h050, 32'hFFFFFFFF);
    wr(12'h040, mk(8'h10, 8'h00, 1'b0, 1'b1));
    wait_idle(n);   check("R6", "bad key burn busy cycles", n, 0);
    repeat (LAT + 2) @(negedge clk);
    rd(12'h210, v); check("R6", "word 4 untouched", v, 32'h0);
  endtask

  task automatic t_busy();
    logic [31:0] v; int n;
    wr(12'h040, mk(8'h08, 8'hAC, 1'b1, 1'b0));
    wr(12'h040, mk(8'h10, 8'hAC, 1'b0, 1'b1));
    rd(12'h040, v); check("R7", "cmd unchanged while busy", v, 32'h0008AC02);
    wait_idle(n);
    repeat (LAT + 2) @(negedge clk);
    rd(12'h210, v); check("R7", "ignored burn", v, 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] v; int n;
    wr(12'h050, 32'h0000A5A5);
    wr(12'h040, mk(8'h14, 8'hAC, 1'b0, 1'b1));
    wait_idle(n);
    wr(12'h050, 32'hFF000000);
    wr(12'h040, mk(8'h14, 8'hAC, 1'b1, 1'b1));
    rd(12'h040, v); check("R8", "fetch only", v, 32'h0014AC02);
    wait_idle(n);
    rd(12'h060, v); check("R8", "fetched value", v, 32'h0000A5A5);
    rd(12'h214, v); check("R8", "no burn", v, 32'h0000A5A5);
  endtask

  task automatic t_lock();
    logic [31:0] v; int n;
    wr(12'h050, 32'hDEADBEEF);
    wr(12'h040, mk(8'h30, 8'hAC, 1'b0, 1'b1));
    wait_idle(n);
    rd(12'h230, v); check("R9", "locked word 12 hidden", v, 32'h0);
    wr(12'h040, mk(8'h30, 8'hAC, 1'b1, 1'b0));
    wait_idle(n);
    rd(12'h060, v); check("R9", "locked word via command", v, 32'hDEADBEEF);
    wr(12'h040, mk(8'h3C, 8'hAC, 1'b0, 1'b1));
    wait_idle(n);
    rd(12'h23C, v); check("R9", "locked word 15 hidden", v, 32'h0);
    wr(12'h040, mk(8'h40, 8'hAC, 1'b0, 1'b1));
    wait_idle(n);
    rd(12'h240, v); check("R9", "word 16 visible", v, 32'hDEADBEEF);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    wr(12'h208, 32'h0);
    rd(12'h208, v); check("R10", "window write ignored", v, 32'h443322F1);
    wr(12'h060, 32'h12345678);
    rd(12'h060, v); check("R10", "result write ignored", v, 32'hDEADBEEF);
    wr(12'h100, 32'h87654321);
    rd(12'h100, v); check("R10", "undefined 0x100", v, 32'h0);
    rd(12'h044, v); check("R10", "undefined 0x044", v, 32'h0);
    rd(12'h300, v); check("R10", "past window", v, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burn();
    t_fetch();
    t_lanes();
    t_badkey();
    t_busy();
    t_both();
    t_lock();
    t_ignore();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule